// File: doc/BRIEF.md
# Banked Memory Map Address Decoder

This block sits between an 8-bit CPU with a 16-bit address bus and the memories and register blocks around it. On every request it decodes the address into exactly one target and raises that target's chip select. It also drives a target-local offset and passes the write data and the write flag through. It keeps the switchable work RAM bank number. It forwards writes in the ROM window to the bank controller as control writes. It gates sprite attribute RAM on the video mode. It returns an open-bus value of all ones for regions that are disabled or unusable.

Each target presents its read data combinationally on a shared flat read bus, in the slot given by its chip-select index. The decoder registers the selected slot and returns it one cycle after the request, together with a read-valid flag.

Top module: `mem_map_decoder`

## Requirements
- R1: A read in 0x0000-0x3FFF selects the fixed ROM target and a read in 0x4000-0x7FFF selects the switchable ROM target, both with offset = addr[13:0]. 0x8000-0x9FFF selects video RAM with offset addr[12:0]. 0xC000-0xCFFF selects fixed work RAM with offset addr[11:0]. The chip-select bit order is 0 fixed ROM, 1 switchable ROM, 2 video RAM, 3 external RAM, 4 clock register, 5 fixed work RAM, 6 switchable work RAM, 7 sprite RAM, 8 I/O, 9 high RAM, 10 interrupt enable.
- R2: A write anywhere in 0x0000-0x7FFF raises ctl_wr_o and asserts no chip select.
- R3: A bank write keeps only data bits [2:0], and the value 0 becomes 1. The bank register resets to 1. An access to 0xD000-0xDFFF selects switchable work RAM with offset = {bank, addr[11:0]}.
- R4: 0xE000-0xEFFF mirrors fixed work RAM (offset addr[11:0]). 0xF000-0xFDFF mirrors the switchable bank.
- R5: 0xFE00-0xFE9F selects sprite RAM with offset addr[7:0] only when vid_mode_i is 0 or 1. Otherwise no select is raised, reads return 0xFF and writes reach no target.
- R6: 0xFEA0-0xFEFF raises no select. Reads there return 0xFF.
- R7: In 0xA000-0xBFFF, clock-register mode selects the clock register target regardless of the RAM enable. Otherwise the RAM enable selects external RAM (offset addr[12:0]). With neither active, no select is raised and reads return 0xFF.
- R8: 0xFF00-0xFF7F selects I/O with offset addr[6:0]. 0xFF80-0xFFFE selects high RAM with offset addr[6:0]. 0xFFFF selects the interrupt-enable target.
- R9: A read returns the selected target's slot of rd_bus_i, or 0xFF when nothing is selected, on rdata_o with rvalid_o high in the cycle after the request. Writes leave rvalid_o low.
- R10: At most one chip select is high. With no request, no select and no control write are raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | CPU address |
| req_wdata_i | input | DATA_W | Write data |
| vid_mode_i | input | 2 | Current video mode |
| xram_en_i | input | 1 | External RAM access enabled |
| clk_mode_i | input | 1 | Clock-register access mode active |
| bank_we_i | input | 1 | Load work RAM bank register |
| bank_wdata_i | input | DATA_W | Bank register write value |
| rd_bus_i | input | NUM_TGT*DATA_W | Per-target read data, slot i for select i |
| cs_o | output | NUM_TGT | One-hot target chip selects |
| we_o | output | 1 | Write flag to targets |
| offset_o | output | OFS_W | Target-local offset |
| wdata_o | output | DATA_W | Write data to targets |
| ctl_wr_o | output | 1 | Control write to bank controller |
| rdata_o | output | DATA_W | Registered read data |
| rvalid_o | output | 1 | Read data valid |

## Verification
The bench builds the block with its defaults: an 8-bit data path and a 3-bit bank field. With these values every bank from 1 to 7 is reachable, and a bank write with bit 3 set shows that the upper bits are discarded. Every region boundary of the 16-bit map is probed at its first and last address, under each video mode and each external-RAM setting. A behavioural model in the bench predicts the select, offset and registered read data each cycle.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  localparam int NUM_TGT = 11;
  typedef enum logic [3:0] {
    T_ROM0   = 4'd0,
    T_ROMX   = 4'd1,
    T_VRAM   = 4'd2,
    T_XRAM   = 4'd3,
    T_CLKREG = 4'd4,
    T_WRAM0  = 4'd5,
    T_WRAMX  = 4'd6,
    T_OAM    = 4'd7,
    T_IO     = 4'd8,
    T_HRAM   = 4'd9,
    T_IE     = 4'd10,
    T_NONE   = 4'd15
  } tgt_e;
endpackage

// File: rtl/mm_region_decode.sv
module mm_region_decode
  import memmap_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int OFS_W  = 15
) (
  input  logic [15:0]       addr_i,
  input  logic              we_i,
  input  logic [1:0]        vid_mode_i,
  input  logic              xram_en_i,
  input  logic              clk_mode_i,
  input  logic [BANK_W-1:0] bank_i,
  output tgt_e              tgt_o,
  output logic [OFS_W-1:0]  ofs_o,
  output logic              ctl_o
);
  always_comb begin
    tgt_o = T_NONE;
    ofs_o = '0;
    ctl_o = 1'b0;
    case (addr_i[15:12])
      4'h0, 4'h1, 4'h2, 4'h3: begin
        if (we_i) ctl_o = 1'b1;
        else begin tgt_o = T_ROM0; ofs_o = OFS_W'(addr_i[13:0]); end
      end
      4'h4, 4'h5, 4'h6, 4'h7: begin
        if (we_i) ctl_o = 1'b1;
        else begin tgt_o = T_ROMX; ofs_o = OFS_W'(addr_i[13:0]); end
      end
      4'h8, 4'h9: begin tgt_o = T_VRAM; ofs_o = OFS_W'(addr_i[12:0]); end
      4'hA, 4'hB: begin
        if (clk_mode_i) tgt_o = T_CLKREG;
        else if (xram_en_i) begin tgt_o = T_XRAM; ofs_o = OFS_W'(addr_i[12:0]); end
      end
      4'hC, 4'hE: begin tgt_o = T_WRAM0; ofs_o = OFS_W'(addr_i[11:0]); end
      4'hD: begin tgt_o = T_WRAMX; ofs_o = OFS_W'({bank_i, addr_i[11:0]}); end
      default: begin
        if (addr_i < 16'hFE00) begin
          tgt_o = T_WRAMX; ofs_o = OFS_W'({bank_i, addr_i[11:0]});
        end else if (addr_i < 16'hFEA0) begin
          // sprite RAM only while video is not scanning it
          if (vid_mode_i < 2'd2) begin tgt_o = T_OAM; ofs_o = OFS_W'(addr_i[7:0]); end
        end else if (addr_i < 16'hFF00) begin
          tgt_o = T_NONE;
        end else if (addr_i < 16'hFF80) begin
          tgt_o = T_IO; ofs_o = OFS_W'(addr_i[6:0]);
        end else if (addr_i != 16'hFFFF) begin
          tgt_o = T_HRAM; ofs_o = OFS_W'(addr_i[6:0]);
        end else begin
          tgt_o = T_IE;
        end
      end
    endcase
  end
endmodule

// File: rtl/mm_bank_reg.sv
module mm_bank_reg #(
  parameter int BANK_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [BANK_W-1:0] bank_o
);
  logic [BANK_W-1:0] sel;
  assign sel = wdata_i[BANK_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bank_o <= BANK_W'(1);
    else if (we_i) bank_o <= (sel == '0) ? BANK_W'(1) : sel;
  end
endmodule

// File: rtl/mm_read_mux.sv
module mm_read_mux
  import memmap_pkg::*;
#(
  parameter int NT     = 11,
  parameter int DATA_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_en_i,
  input  tgt_e               tgt_i,
  input  logic [NT*DATA_W-1:0] rd_bus_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rvalid_o
);
  logic [DATA_W-1:0] sel_d;

  always_comb begin
    sel_d = '1; // open bus
    for (int i = 0; i < NT; i++)
      if (tgt_i == tgt_e'(i)) sel_d = rd_bus_i[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '1;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= sel_d;
    end
  end
endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
  import memmap_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BANK_W  = 3,
  parameter int NUM_T   = memmap_pkg::NUM_TGT,
  parameter int OFS_W   = (BANK_W + 12 > 14) ? BANK_W + 12 : 14
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic                    req_we_i,
  input  logic [15:0]             req_addr_i,
  input  logic [DATA_W-1:0]       req_wdata_i,
  input  logic [1:0]              vid_mode_i,
  input  logic                    xram_en_i,
  input  logic                    clk_mode_i,
  input  logic                    bank_we_i,
  input  logic [DATA_W-1:0]       bank_wdata_i,
  input  logic [NUM_T*DATA_W-1:0] rd_bus_i,
  output logic [NUM_T-1:0]        cs_o,
  output logic                    we_o,
  output logic [OFS_W-1:0]        offset_o,
  output logic [DATA_W-1:0]       wdata_o,
  output logic                    ctl_wr_o,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    rvalid_o
);
  tgt_e              tgt;
  logic              ctl;
  logic [BANK_W-1:0] bank;

  mm_bank_reg #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_bank (
    .clk_i, .rst_ni, .we_i(bank_we_i), .wdata_i(bank_wdata_i), .bank_o(bank)
  );

  mm_region_decode #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_dec (
    .addr_i(req_addr_i), .we_i(req_we_i), .vid_mode_i, .xram_en_i, .clk_mode_i,
    .bank_i(bank), .tgt_o(tgt), .ofs_o(offset_o), .ctl_o(ctl)
  );

  for (genvar i = 0; i < NUM_T; i++) begin : g_cs
    assign cs_o[i] = req_valid_i && (tgt == tgt_e'(i));
  end

  assign ctl_wr_o = req_valid_i && ctl;
  assign we_o     = req_we_i;
  assign wdata_o  = req_wdata_i;

  mm_read_mux #(.NT(NUM_T), .DATA_W(DATA_W)) u_rmux (
    .clk_i, .rst_ni, .rd_en_i(req_valid_i && !req_we_i), .tgt_i(tgt),
    .rd_bus_i, .rdata_o, .rvalid_o
  );
endmodule

// File: rtl/mem_map_chk.sv
module mem_map_chk #(
  parameter int DATA_W = 8,
  parameter int BANK_W = 3,
  parameter int NUM_T  = 11,
  parameter int OFS_W  = 15
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_valid_i,
  input logic                    req_we_i,
  input logic [15:0]             req_addr_i,
  input logic [1:0]              vid_mode_i,
  input logic                    xram_en_i,
  input logic                    clk_mode_i,
  input logic [NUM_T-1:0]        cs_o,
  input logic [OFS_W-1:0]        offset_o,
  input logic                    ctl_wr_o,
  input logic [DATA_W-1:0]       rdata_o,
  input logic                    rvalid_o
);
  logic rd_req;
  assign rd_req = req_valid_i && !req_we_i;

  assert_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));
  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (cs_o == '0 && !ctl_wr_o));
  assert_ctl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr_o |-> (req_we_i && !req_addr_i[15] && cs_o == '0));
  assert_oam_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i >= 16'hFE00 && req_addr_i < 16'hFEA0 && vid_mode_i >= 2'd2)
    |-> cs_o == '0);
  assert_hole_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && req_addr_i >= 16'hFEA0 && req_addr_i < 16'hFF00) |=> rdata_o == '1);
  assert_xram_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && req_addr_i[15:13] == 3'b101 && !xram_en_i && !clk_mode_i) |=> rdata_o == '1);
  assert_bank_nz_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o[6] |-> offset_o[12 +: BANK_W] != '0);
  assert_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rvalid_o);
endmodule

bind mem_map_decoder mem_map_chk #(
  .DATA_W(DATA_W), .BANK_W(BANK_W), .NUM_T(NUM_T), .OFS_W(OFS_W)
) u_chk (.*);

// File: tb/tb_mem_map_decoder.sv
module tb_mem_map_decoder;
  localparam int DW = 8, BW = 3, NT = 11, OW = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_we = 0, xen = 0, ckm = 0, bank_we = 0;
  logic [15:0] addr = '0;
  logic [DW-1:0] wdata = '0, bank_wdata = '0;
  logic [1:0] vmode = '0;
  logic [NT*DW-1:0] rd_bus;
  logic [NT-1:0] cs;
  logic we_o, ctl_wr, rvalid;
  logic [OW-1:0] ofs;
  logic [DW-1:0] wdata_o, rdata;

  mem_map_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_we_i(req_we),
    .req_addr_i(addr), .req_wdata_i(wdata), .vid_mode_i(vmode), .xram_en_i(xen),
    .clk_mode_i(ckm), .bank_we_i(bank_we), .bank_wdata_i(bank_wdata),
    .rd_bus_i(rd_bus), .cs_o(cs), .we_o(we_o), .offset_o(ofs), .wdata_o(wdata_o),
    .ctl_wr_o(ctl_wr), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  int n_tests = 0, n_fail = 0, bank_m = 1;
  bit done = 0;

  initial for (int t = 0; t < NT; t++) rd_bus[t*DW +: DW] = 8'h30 + 8'(t * 17);

  task automatic chk(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic int m_tgt(int a, bit w);
    if (a < 16'h8000) return w ? -1 : (a < 16'h4000 ? 0 : 1);
    if (a < 16'hA000) return 2;
    if (a < 16'hC000) return ckm ? 4 : (xen ? 3 : -1);
    if (a < 16'hD000) return 5;
    if (a < 16'hE000) return 6;
    if (a < 16'hF000) return 5;
    if (a < 16'hFE00) return 6;
    if (a < 16'hFEA0) return (vmode <= 1) ? 7 : -1;
    if (a < 16'hFF00) return -1;
    if (a < 16'hFF80) return 8;
    if (a < 16'hFFFF) return 9;
    return 10;
  endfunction

  function automatic int m_ofs(int t, int a);
    case (t)
      0, 1: return a % 16384;
      2, 3: return a % 8192;
      5: return a % 4096;
      6: return bank_m * 4096 + a % 4096;
      7: return a % 256;
      8, 9: return a % 128;
      default: return 0;
    endcase
  endfunction

  task automatic access(string req, bit w, int a);
    int t;
    @(negedge clk);
    req_valid = 1; req_we = w; addr = 16'(a); wdata = 8'(a ^ 8'h5A);
    #1;
    t = m_tgt(a, w);
    chk(req, $sformatf("cs @%h", a), cs, (t < 0) ? 0 : (1 << t));
    if (t >= 0) chk(req, $sformatf("ofs @%h", a), ofs, m_ofs(t, a));
    chk(req, $sformatf("ctl @%h", a), ctl_wr, (w && a < 16'h8000) ? 1 : 0);
    @(posedge clk); #1;
    req_valid = 0;
    chk("R9", $sformatf("rvalid @%h", a), rvalid, w ? 0 : 1);
    if (!w) chk(req, $sformatf("rdata @%h", a), rdata, (t < 0) ? 8'hFF : 8'h30 + 8'(t * 17));
  endtask

  task automatic set_bank(int v);
    @(negedge clk);
    bank_we = 1; bank_wdata = 8'(v);
    @(posedge clk); #1;
    bank_we = 0;
    bank_m = (v % 8 == 0) ? 1 : v % 8;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R10", "idle cs", cs, 0);
    chk("R10", "idle ctl", ctl_wr, 0);
    chk("R9", "reset rvalid", rvalid, 0);
    access("R3", 0, 16'hD000); // reset bank 1
    access("R1", 0, 16'h0000); access("R1", 0, 16'h3FFF);
    access("R1", 0, 16'h4000); access("R1", 0, 16'h7FFF);
    access("R1", 0, 16'h8000); access("R1", 1, 16'h9FFF);
    access("R1", 0, 16'hC000); access("R1", 1, 16'hCFFF);
    access("R2", 1, 16'h0000); access("R2", 1, 16'h2100); access("R2", 1, 16'h7FFF);
    set_bank(0);  access("R3", 0, 16'hD123);
    set_bank(5);  access("R3", 1, 16'hDFFF);
    set_bank(8'h0B); access("R3", 0, 16'hD800);
    set_bank(8'h08); access("R3", 0, 16'hD001);
    set_bank(7);  access("R3", 0, 16'hD456);
    access("R4", 0, 16'hE000); access("R4", 1, 16'hEFFF);
    access("R4", 0, 16'hF000); access("R4", 0, 16'hFDFF);
    for (int m = 0; m < 4; m++) begin
      vmode = 2'(m);
      access("R5", 0, 16'hFE00); access("R5", 0, 16'hFE9F); access("R5", 1, 16'hFE42);
    end
    vmode = 0;
    access("R6", 0, 16'hFEA0); access("R6", 0, 16'hFEFF); access("R6", 1, 16'hFEB0);
    xen = 0; ckm = 0; access("R7", 0, 16'hA000); access("R7", 1, 16'hBFFF);
    xen = 1; access("R7", 0, 16'hA000); access("R7", 0, 16'hBFFF);
    ckm = 1; access("R7", 0, 16'hA010); access("R7", 1, 16'hB000);
    xen = 0; access("R7", 0, 16'hA001);
    ckm = 0;
    access("R8", 0, 16'hFF00); access("R8", 0, 16'hFF7F);
    access("R8", 0, 16'hFF80); access("R8", 1, 16'hFFFE); access("R8", 0, 16'hFFFF);
    @(negedge clk);
    chk("R10", "idle cs end", cs, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule